// File: doc/BRIEF.md
# Paired-Byte Event Message Serial Transmitter

This block turns two kinds of capture events into fixed 16-bit messages and sends each message to a host over one asynchronous serial line. The first kind is a received character, which carries eight payload bits, the parity bit, the line level sampled in the middle of the start bit, and an error-signal flag. The second kind is a change of the reset line, which carries the new reset level. Each message leaves as two 8N1 bytes, low byte first. The two bytes form one unbroken 20-bit shift, so the host only ever receives complete byte pairs. After a pause, the host can drop a lone first byte and regain alignment.

Each serial bit lasts `BAUD_DIV` system clocks. With the default of 4 and a 12 MHz system clock, the line runs at 3 Mbps. Upstream logic offers events with valid strobes and must respect `ready`. The block holds at most one message beyond the one being shifted. That slot is used only when both kinds of event arrive in the same cycle.

Top module: `evt_pair_uart_tx`

## Requirements
- R1: After reset, `tx` is high (idle) and `ready` is high.
- R2: A character message word has bit 15 = 0, bit 14 = 1, bits 13..11 = 0, bit 10 = error flag, bit 9 = start-bit midpoint sample, bit 8 = parity and bits 7..0 = payload.
- R3: A reset-change message word has bit 15 = 1, bit 14 = the new reset level, and bits 13..0 = 0.
- R4: A message goes out as 20 consecutive bit periods in this order: start (0), word bits 0..7, stop (1), start (0), word bits 8..15, stop (1). There is no idle time between the two bytes.
- R5: Every bit period lasts exactly `BAUD_DIV` clock cycles. The first bit period begins at the clock edge that accepts the event.
- R6: `ready` is low from the accepting edge until the final stop bit has completed. It returns high `20*BAUD_DIV` cycles after acceptance when nothing else is queued.
- R7: A valid strobe presented while `ready` is low is ignored: it produces no message and does not change the message in flight.
- R8: If a character event and a reset-change event are accepted in the same cycle, the reset-change message is sent first. The character message follows directly after it with no idle bit, and `ready` stays low across both messages.
- R9: Whenever no message is being shifted, `tx` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_valid | input | 1 | Character event strobe |
| chr_data | input | 8 | Character payload bits |
| chr_parity | input | 1 | Received parity bit |
| chr_start_smp | input | 1 | Line level sampled at start-bit midpoint |
| chr_err | input | 1 | Error signal was seen on this character |
| rstev_valid | input | 1 | Reset-line change event strobe |
| rstev_level | input | 1 | New level of the reset line |
| ready | output | 1 | High when a new event can be accepted |
| tx | output | 1 | Serial output line, idles high |

## Verification
Event acceptance and message emission can coincide. A character and a reset change may both be accepted on one edge, while at the same time the pending slot is filled and the shifter is loaded. The bench provokes this with a directed case and with random cycles that raise both strobes together. It decodes 40 consecutive bit periods and expects the reset-change frame first, then the character frame with no gap between them, and `ready` low throughout. The bench also raises a strobe in the middle of a frame and expects the decoded bits and the idle line that follows to be unchanged.

// File: rtl/evt_pair_pkg.sv
package evt_pair_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int FRAME_W = 2 * (BYTE_W + 2);

  typedef logic [WORD_W-1:0]  evt_word_t;
  typedef logic [FRAME_W-1:0] evt_frame_t;

  // Two 8N1 bytes, low byte first; index 0 is the first bit on the line.
  function automatic evt_frame_t pack_frame(input evt_word_t w);
    return {1'b1, w[WORD_W-1:BYTE_W], 1'b0, 1'b1, w[BYTE_W-1:0], 1'b0};
  endfunction
endpackage

// File: rtl/evt_word_fmt.sv
module evt_word_fmt
  import evt_pair_pkg::*;
(
  input  logic [BYTE_W-1:0] chr_data,
  input  logic              chr_parity,
  input  logic              chr_start_smp,
  input  logic              chr_err,
  input  logic              rstev_level,
  output evt_word_t         chr_word,
  output evt_word_t         rst_word
);
  // Character message: kind=0, level field fixed at 1, three reserved zeros.
  assign chr_word = {1'b0, 1'b1, 3'b000, chr_err, chr_start_smp, chr_parity, chr_data};
  // Reset-line message: kind=1, new level, remaining bits cleared.
  assign rst_word = {1'b1, rstev_level, {(WORD_W-2){1'b0}}};
endmodule

// File: rtl/evt_pair_sched.sv
module evt_pair_sched
  import evt_pair_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      chr_valid,
  input  evt_word_t chr_word,
  input  logic      rstev_valid,
  input  evt_word_t rst_word,
  input  logic      busy,
  input  logic      done,
  output logic      load,
  output evt_word_t load_word,
  output logic      ready
);
  logic      pend_v;
  evt_word_t pend_word;
  logic      take_chr, take_rst, drain;

  assign ready    = !busy && !pend_v;
  assign take_chr = ready && chr_valid;
  assign take_rst = ready && rstev_valid;
  assign drain    = done && pend_v;

  assign load      = take_chr || take_rst || drain;
  assign load_word = drain ? pend_word : (take_rst ? rst_word : chr_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_word <= '0;
    end else if (drain) begin
      pend_v    <= 1'b0;
    end else if (take_chr && take_rst) begin
      pend_v    <= 1'b1;
      pend_word <= chr_word;
    end
  end

  // A queued message always waits behind a frame in flight (R8).
  p_pend_behind_busy_r8: assert property (@(posedge clk) disable iff (rst)
    pend_v |-> busy);
  // When the frame ends with a message queued, the next one starts at once (R8).
  p_pend_chained_r8: assert property (@(posedge clk) disable iff (rst)
    (done && pend_v) |=> (busy && !pend_v));
endmodule

// File: rtl/evt_frame_tx.sv
module evt_frame_tx
  import evt_pair_pkg::*;
#(
  parameter int BAUD_DIV = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  evt_word_t load_word,
  output logic      busy,
  output logic      done,
  output logic      tx
);
  localparam int DIV_W = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BAUD_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  evt_frame_t       sh_q;
  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic             busy_q, tx_q;
  evt_frame_t       frame_in;

  assign frame_in = pack_frame(load_word);
  assign busy     = busy_q;
  assign tx       = tx_q;
  assign done     = busy_q && (div_q == DIV_LAST) && (bit_q == BIT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      div_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      tx_q   <= 1'b1;
    end else if (load) begin
      sh_q   <= frame_in;
      tx_q   <= frame_in[0];
      div_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (bit_q == BIT_LAST) begin
          busy_q <= 1'b0;
          tx_q   <= 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= sh_q >> 1;
          tx_q  <= sh_q[1];
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // A new frame may only be loaded into an idle or just-finishing shifter (R7).
  p_load_when_free_r7: assert property (@(posedge clk) disable iff (rst)
    load |-> (!busy_q || done));
  // A started frame is never cut short (R4).
  p_frame_atomic_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done) |=> busy_q);
  // The line rests high when nothing is shifting (R9).
  p_idle_high_r9: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> tx_q);
endmodule

// File: rtl/evt_pair_uart_tx.sv
module evt_pair_uart_tx
  import evt_pair_pkg::*;
#(
  parameter int BAUD_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chr_valid,
  input  logic [BYTE_W-1:0] chr_data,
  input  logic              chr_parity,
  input  logic              chr_start_smp,
  input  logic              chr_err,
  input  logic              rstev_valid,
  input  logic              rstev_level,
  output logic              ready,
  output logic              tx
);
  evt_word_t chr_word, rst_word, load_word;
  logic      load, busy, done;

  evt_word_fmt u_fmt (
    .chr_data      (chr_data),
    .chr_parity    (chr_parity),
    .chr_start_smp (chr_start_smp),
    .chr_err       (chr_err),
    .rstev_level   (rstev_level),
    .chr_word      (chr_word),
    .rst_word      (rst_word)
  );

  evt_pair_sched u_sched (
    .clk         (clk),
    .rst         (rst),
    .chr_valid   (chr_valid),
    .chr_word    (chr_word),
    .rstev_valid (rstev_valid),
    .rst_word    (rst_word),
    .busy        (busy),
    .done        (done),
    .load        (load),
    .load_word   (load_word),
    .ready       (ready)
  );

  evt_frame_tx #(.BAUD_DIV(BAUD_DIV)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_word (load_word),
    .busy      (busy),
    .done      (done),
    .tx        (tx)
  );

  // Shifting and accepting never overlap (R6).
  p_busy_blocks_ready_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ready);
endmodule

// File: tb/evt_pair_uart_tx_tb_top.sv
module evt_pair_uart_tx_tb_top;
  localparam int BAUD_DIV = 4;
  localparam int FBITS    = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chr_valid = 1'b0;
  logic [7:0] chr_data = '0;
  logic       chr_parity = 1'b0, chr_start_smp = 1'b0, chr_err = 1'b0;
  logic       rstev_valid = 1'b0, rstev_level = 1'b0;
  logic       ready, tx;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  evt_pair_uart_tx #(.BAUD_DIV(BAUD_DIV)) dut_i (
    .clk(clk), .rst(rst), .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_parity(chr_parity), .chr_start_smp(chr_start_smp), .chr_err(chr_err),
    .rstev_valid(rstev_valid), .rstev_level(rstev_level), .ready(ready), .tx(tx)
  );

  function automatic logic [15:0] exp_chr(input logic [7:0] d, input logic par,
                                          input logic smp, input logic err);
    logic [15:0] w = '0;
    w[14] = 1'b1; w[10] = err; w[9] = smp; w[8] = par; w[7:0] = d;
    return w;
  endfunction

  function automatic logic [15:0] exp_rst(input logic lvl);
    logic [15:0] w = '0;
    w[15] = 1'b1; w[14] = lvl;
    return w;
  endfunction

  function automatic logic [19:0] exp_frame(input logic [15:0] w);
    logic [19:0] f;
    f[0] = 1'b0; f[9] = 1'b1; f[10] = 1'b0; f[19] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      f[1+i]  = w[i];
      f[11+i] = w[8+i];
    end
    return f;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Present events at a falling edge; acceptance happens on the next rising edge.
  task automatic issue(input bit do_chr, input bit do_rst, input logic [7:0] d,
                       input logic par, input logic smp, input logic err, input logic lvl);
    @(negedge clk);
    chr_valid = do_chr; chr_data = d; chr_parity = par; chr_start_smp = smp; chr_err = err;
    rstev_valid = do_rst; rstev_level = lvl;
    @(posedge clk);
  endtask

  // Sample each bit in the middle of its period; poke raises a strobe mid-frame.
  task automatic capture(input int nfr, input bit poke, output logic [39:0] bits,
                         output int bad_stab, output int bad_rdy);
    logic held;
    bits = '0; bad_stab = 0; bad_rdy = 0; held = 1'b0;
    for (int n = 0; n < nfr * FBITS * BAUD_DIV; n++) begin
      @(negedge clk);
      if (n == 0) begin chr_valid = 1'b0; rstev_valid = 1'b0; end
      if (poke && n == 40) begin chr_valid = 1'b1; rstev_valid = 1'b1; chr_data = 8'h5A; end
      if (poke && n == 41) begin chr_valid = 1'b0; rstev_valid = 1'b0; end
      if (ready !== 1'b0) bad_rdy++;
      if (n % BAUD_DIV == 0) held = tx;
      else if (tx !== held) bad_stab++;
      if (n % BAUD_DIV == 1) bits[n / BAUD_DIV] = tx;
    end
  endtask

  task automatic run_one(input string tag, input int kind, input bit poke,
                         input logic [7:0] d, input logic par, input logic smp,
                         input logic err, input logic lvl);
    logic [39:0] bits, expb;
    logic [15:0] wc, wr;
    int bs, br, nfr;
    wc = exp_chr(d, par, smp, err);
    wr = exp_rst(lvl);
    nfr = (kind == 2) ? 2 : 1;
    if (kind == 0)      expb = {20'h0, exp_frame(wc)};
    else if (kind == 1) expb = {20'h0, exp_frame(wr)};
    else                expb = {exp_frame(wc), exp_frame(wr)};
    issue(kind != 1, kind != 0, d, par, smp, err, lvl);
    capture(nfr, poke, bits, bs, br);
    check({tag, " R2 R3 R4 R8 frame bits"}, 64'(bits), 64'(expb));
    check({tag, " R5 bit period stable"}, 64'(bs), 64'd0);
    check({tag, " R6 R8 ready low in frame"}, 64'(br), 64'd0);
    @(negedge clk);
    check({tag, " R6 ready back"}, 64'(ready), 64'd1);
    check({tag, " R9 idle high"}, 64'(tx), 64'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired got=running exp=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 reset tx", 64'(tx), 64'd1);
    check("R1 reset ready", 64'(ready), 64'd1);

    // Directed corner cases.
    run_one("chr all-ones", 0, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0);
    run_one("chr zeros", 0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    run_one("rst high", 1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    run_one("rst low", 1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    run_one("both same cycle", 2, 1'b0, 8'hA5, 1'b1, 1'b0, 1'b1, 1'b1);
    // R7: strobes raised mid-frame must leave no trace.
    run_one("R7 ignore mid-frame", 0, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0);
    begin
      int moved = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (tx !== 1'b1 || ready !== 1'b1) moved++;
      end
      check("R7 no extra message", 64'(moved), 64'd0);
    end

    // Random mix.
    for (int i = 0; i < 40; i++) begin
      int k;
      logic [7:0] rd;
      k = int'($urandom_range(2, 0));
      rd = 8'($urandom());
      run_one("random", k, 1'b0, rd, 1'($urandom()), 1'($urandom()),
              1'($urandom()), 1'($urandom()));
      repeat (int'($urandom_range(3, 0))) @(negedge clk);
    end
    finish_run();
  end
endmodule